// File: doc/BRIEF.md
# Clock-Loss Monitor with Reset Generation

This block watches a monitored clock against a slow, free-running reference clock and raises a system reset when the monitored clock stops or runs too slowly. A Gray-coded edge counter runs on the monitored clock. A two-flop synchronizer carries the counter into the reference domain, where it is converted back to binary. A window timer in the reference domain takes the difference of that count over a fixed number of reference cycles. Because the counter value simply holds still when the monitored clock stops, a stopped clock is measured as a window with zero edges and needs no special handling.

Two thresholds give the decision hysteresis. While armed, the monitor fires only on a window with fewer than `LOSS_EDGES` edges (one by default, so zero edges). A window with fewer than `HEALTHY_EDGES` edges (twenty by default) is never taken as proof of a good clock. Once fired, the monitor drives a reset request for exactly `PULSE_CYCLES` reference cycles. It then waits, without firing again, until a full window shows at least `HEALTHY_EDGES` edges. An enable input turns the function on and off. The first window after enable rises is always discarded.

Top module: `clock_monitor`

## Requirements
- R1: While armed and enabled, a monitored clock that gives at least one edge per window, such as any period from 2 to 16 ns against a 320 ns window, never asserts the reset request.
- R2: While armed and enabled, if the monitored clock stops, the reset request asserts within three windows plus a few reference cycles, and only at the end of a window that counted fewer than `LOSS_EDGES` edges.
- R3: `rst_pin_n` is low in exactly the cycles in which `rst_req` is high.
- R4: With `enable` at 0 the reset request never asserts. Dropping `enable` during a pulse releases the request by the next reference cycle.
- R5: A pulse that is not cut short by `enable` lasts exactly `PULSE_CYCLES` reference cycles (4 by default).
- R6: After a pulse, no new pulse is generated until a complete window has counted at least `HEALTHY_EDGES` edges. A window of 18 or 19 edges does not re-arm the monitor.
- R7: After `enable` rises, the first window is discarded. No request appears within `WIN_CYCLES` reference cycles of the rise, even with the monitored clock stopped. The following empty window fires the monitor.
- R8: While armed, a slow clock that gives between `LOSS_EDGES` and `HEALTHY_EDGES - 1` edges per window does not fire the monitor.
- R9: While `rst_n` is low, `rst_req` is 0 and `rst_pin_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Monitored clock whose presence is checked |
| ref_clk | input | 1 | Slow free-running reference clock that times the windows |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both clock domains |
| enable | input | 1 | 1 turns the monitor on; 0 holds it idle with no request |
| rst_req | output | 1 | Reset request, high while the monitor fires |
| rst_pin_n | output | 1 | Active-low reset drive for the external system |

## Verification
The assertions assume that `mon_clk` runs while `rst_n` is low, so that the monitored-domain counter starts from a known value. They also assume that the monitored clock gives fewer edges per window than the counter range, so that the window difference does not wrap. The stimulus meets both conditions. It holds the monitored clock at a 10 ns period during reset, and the fastest period used, 2 ns, gives 160 edges against an 8-bit counter. Monitored-clock edges are placed at fractional-nanosecond offsets so that they do not coincide with reference edges. This keeps the 15- and 17-ns boundary cases on known sides of the 20-edge threshold.

// File: rtl/clock_monitor_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the clock-loss monitor.
// Assumes: nothing beyond a SystemVerilog-2017 compiler.
package clock_monitor_pkg;

    // Monitor control states, all in the reference-clock domain.
    typedef enum logic [2:0] {
        MS_IDLE    = 3'd0,  // disabled, window timer held
        MS_SETTLE  = 3'd1,  // first window after enable, result discarded
        MS_ARMED   = 3'd2,  // watching for an empty window
        MS_FIRE    = 3'd3,  // driving the reset pulse
        MS_RECOVER = 3'd4   // waiting for a healthy window before re-arming
    } mon_state_t;

endpackage

// File: rtl/clock_monitor_edge_counter.sv
`timescale 1ns/1ps
// Module: free-running edge counter in the monitored-clock domain.
// Counts rising edges of mon_clk and presents the count as a registered
// Gray code, so that one bit changes per edge and the value can be sampled
// safely by another clock domain.
// Assumes: mon_clk toggles while rst_n is low, so the reset takes effect.
// If mon_clk stops, the output holds its last value.
module clock_monitor_edge_counter #(
    parameter int CNT_W = 8
) (
    input  logic             mon_clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] gray_o
);

    logic [CNT_W-1:0] bin_q;
    logic [CNT_W-1:0] bin_nxt;

    // Next binary count.
    assign bin_nxt = bin_q + 1'b1;

    // Advance the binary count and register its Gray image.
    always_ff @(posedge mon_clk) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_o <= '0;
        end else begin
            bin_q  <= bin_nxt;
            gray_o <= bin_nxt ^ (bin_nxt >> 1);
        end
    end

endmodule

// File: rtl/clock_monitor_gray_sync.sv
`timescale 1ns/1ps
// Module: multi-stage synchronizer for a Gray-coded count, with conversion
// back to binary in the destination (reference) domain.
// Assumes: the source changes by at most one Gray step between two samples
// of the destination clock, or else only the window difference is used.
module clock_monitor_gray_sync #(
    parameter int CNT_W  = 8,
    parameter int STAGES = 2
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] gray_i,
    output logic [CNT_W-1:0] bin_o
);

    logic [CNT_W-1:0] stage_q [STAGES];

    // First stage samples the asynchronous Gray count.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= gray_i;
    end

    // Further stages of the synchronizer chain.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge ref_clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    // Gray to binary: each bit is the XOR of all Gray bits at or above it.
    always_comb begin
        bin_o = '0;
        bin_o[CNT_W-1] = stage_q[STAGES-1][CNT_W-1];
        for (int b = CNT_W - 2; b >= 0; b--) begin
            bin_o[b] = bin_o[b+1] ^ stage_q[STAGES-1][b];
        end
    end

endmodule

// File: rtl/clock_monitor_window.sv
`timescale 1ns/1ps
// Module: fixed-length measurement window in the reference domain.
// Every WIN_CYCLES reference cycles it pulses done_o for one cycle and
// presents the number of monitored edges seen since the previous window end.
// restart_i holds the timer at zero and tracks the count as the new base.
// Assumes: fewer than 2**CNT_W monitored edges occur per window.
module clock_monitor_window #(
    parameter int CNT_W      = 8,
    parameter int WIN_CYCLES = 16
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             done_o,
    output logic [CNT_W-1:0] edges_o
);

    localparam int TMR_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WIN_CYCLES - 1);

    logic [TMR_W-1:0] tmr_q;
    logic [CNT_W-1:0] base_q;

    // Window timer, base snapshot and per-window edge difference.
    always_ff @(posedge ref_clk) begin
        if (!rst_n || restart_i) begin
            tmr_q   <= '0;
            base_q  <= count_i;
            done_o  <= 1'b0;
            edges_o <= '0;
        end else if (tmr_q == TMR_LAST) begin
            tmr_q   <= '0;
            base_q  <= count_i;
            done_o  <= 1'b1;
            edges_o <= count_i - base_q;
        end else begin
            tmr_q   <= tmr_q + 1'b1;
            done_o  <= 1'b0;
        end
    end

endmodule

// File: rtl/clock_monitor.sv
`timescale 1ns/1ps
// Module: clock-loss monitor top.
// Counts monitored-clock edges, measures them per reference window and runs
// the arm/fire/recover control with two thresholds for hysteresis. The reset
// request and the active-low pin come from one register.
// Assumes: ref_clk is always running; mon_clk runs during rst_n low.
module clock_monitor #(
    parameter int CNT_W         = 8,
    parameter int SYNC_STAGES   = 2,
    parameter int WIN_CYCLES    = 16,
    parameter int LOSS_EDGES    = 1,
    parameter int HEALTHY_EDGES = 20,
    parameter int PULSE_CYCLES  = 4
) (
    input  logic mon_clk,
    input  logic ref_clk,
    input  logic rst_n,
    input  logic enable,
    output logic rst_req,
    output logic rst_pin_n
);

    import clock_monitor_pkg::*;

    localparam int PCNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [PCNT_W-1:0] PCNT_LAST = PCNT_W'(PULSE_CYCLES - 1);
    localparam logic [CNT_W-1:0]  LOSS_LIM  = CNT_W'(LOSS_EDGES);
    localparam logic [CNT_W-1:0]  OK_LIM    = CNT_W'(HEALTHY_EDGES);

    logic [CNT_W-1:0]  gray_cnt;
    logic [CNT_W-1:0]  ref_cnt;
    logic              win_done;
    logic [CNT_W-1:0]  win_edges;
    mon_state_t        state_q, state_nxt;
    logic [PCNT_W-1:0] pulse_q, pulse_nxt;
    logic              req_q;

    clock_monitor_edge_counter #(.CNT_W(CNT_W)) edge_cnt_i (
        .mon_clk (mon_clk),
        .rst_n   (rst_n),
        .gray_o  (gray_cnt)
    );

    clock_monitor_gray_sync #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) sync_i (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .gray_i  (gray_cnt),
        .bin_o   (ref_cnt)
    );

    clock_monitor_window #(.CNT_W(CNT_W), .WIN_CYCLES(WIN_CYCLES)) win_i (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .restart_i (state_q == MS_IDLE),
        .count_i   (ref_cnt),
        .done_o    (win_done),
        .edges_o   (win_edges)
    );

    // Next-state logic for arm, fire and recover.
    always_comb begin
        state_nxt = state_q;
        pulse_nxt = pulse_q;
        if (!enable) begin
            state_nxt = MS_IDLE;
        end else begin
            unique case (state_q)
                MS_IDLE:    state_nxt = MS_SETTLE;
                MS_SETTLE:  if (win_done) state_nxt = MS_ARMED;
                MS_ARMED: begin
                    if (win_done && (win_edges < LOSS_LIM)) begin
                        state_nxt = MS_FIRE;
                        pulse_nxt = PCNT_LAST;
                    end
                end
                MS_FIRE: begin
                    if (pulse_q == '0) state_nxt = MS_RECOVER;
                    else               pulse_nxt = pulse_q - 1'b1;
                end
                MS_RECOVER: if (win_done && (win_edges >= OK_LIM)) state_nxt = MS_ARMED;
                default:    state_nxt = MS_IDLE;
            endcase
        end
    end

    // State, pulse counter and registered request.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            state_q <= MS_IDLE;
            pulse_q <= '0;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_nxt;
            pulse_q <= pulse_nxt;
            req_q   <= (state_nxt == MS_FIRE);
        end
    end

    assign rst_req   = req_q;
    assign rst_pin_n = ~req_q;

endmodule

// File: rtl/clock_monitor_checker.sv
`timescale 1ns/1ps
// Module: property checker for the clock-loss monitor, bound to the top.
// Watches the request against the enable input and the window results.
// Assumes: the same parameters as the bound instance.
module clock_monitor_checker #(
    parameter int CNT_W         = 8,
    parameter int WIN_CYCLES    = 16,
    parameter int LOSS_EDGES    = 1,
    parameter int HEALTHY_EDGES = 20,
    parameter int PULSE_CYCLES  = 4
) (
    input logic             ref_clk,
    input logic             rst_n,
    input logic             enable,
    input logic             rst_req,
    input logic             win_done,
    input logic [CNT_W-1:0] win_edges
);

    logic [15:0] run_len;
    logic [15:0] en_age;
    logic        need_healthy;

    // Length of the current run of request-high cycles.
    always_ff @(posedge ref_clk) begin
        if (!rst_n || !rst_req) run_len <= '0;
        else if (run_len != 16'hFFFF) run_len <= run_len + 1'b1;
    end

    // Cycles since enable was last seen rising.
    always_ff @(posedge ref_clk) begin
        if (!rst_n || !enable) en_age <= '0;
        else if (en_age != 16'hFFFF) en_age <= en_age + 1'b1;
    end

    // Set by a pulse, cleared by a healthy window seen outside the pulse.
    always_ff @(posedge ref_clk) begin
        if (!rst_n || !enable) need_healthy <= 1'b0;
        else if (rst_req) need_healthy <= 1'b1;
        else if (win_done && (win_edges >= CNT_W'(HEALTHY_EDGES))) need_healthy <= 1'b0;
    end

    assert_fire_on_empty_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(rst_req) |-> ($past(win_done) && ($past(win_edges) < CNT_W'(LOSS_EDGES))));

    assert_disabled_quiet_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !enable |=> !rst_req);

    assert_pulse_length_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ($fell(rst_req) && $past(enable)) |-> (run_len == 16'(PULSE_CYCLES)));

    assert_no_retrigger_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(rst_req) |-> !$past(need_healthy));

    assert_first_window_discarded_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (enable && (en_age < 16'(WIN_CYCLES))) |-> !rst_req);

endmodule

bind clock_monitor clock_monitor_checker #(
    .CNT_W         (CNT_W),
    .WIN_CYCLES    (WIN_CYCLES),
    .LOSS_EDGES    (LOSS_EDGES),
    .HEALTHY_EDGES (HEALTHY_EDGES),
    .PULSE_CYCLES  (PULSE_CYCLES)
) chk_i (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .rst_req   (rst_req),
    .win_done  (win_done),
    .win_edges (win_edges)
);

// File: tb/clock_monitor_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps monitored-clock periods and stop/start patterns against the
// default configuration and checks the reset outputs at the ports.
module clock_monitor_tb_top;

    localparam real REF_PERIOD = 20.0;
    localparam int  WIN        = 16;
    localparam int  PULSE      = 4;
    localparam int  FIRE_LIMIT = 3 * WIN + 6;

    logic mon_clk = 1'b0;
    logic ref_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic enable  = 1'b0;
    logic rst_req;
    logic rst_pin_n;
    real  mon_half = 5.0;

    int checks = 0;
    int errors = 0;

    clock_monitor dut_i (
        .mon_clk   (mon_clk),
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .rst_req   (rst_req),
        .rst_pin_n (rst_pin_n)
    );

    // Reference clock.
    always #(REF_PERIOD / 2.0) ref_clk = ~ref_clk;

    // Monitored clock; half period 0 means stopped.
    always begin
        if (mon_half > 0.0) begin
            #(mon_half) mon_clk = ~mon_clk;
        end else begin
            #(0.37);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Count low-pin cycles over n reference cycles; also count pin/request mismatches.
    task automatic count_lows(input int n, output int lows, output int mism);
        lows = 0;
        mism = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge ref_clk);
            if (!rst_pin_n) lows++;
            if (rst_pin_n != !rst_req) mism++;
        end
    endtask

    // Wait for a pulse within a limit, then measure its length.
    task automatic expect_fire(input int limit, input string tag);
        int waited;
        int len;
        int mism;
        waited = 0;
        len = 0;
        mism = 0;
        while (rst_pin_n && waited < limit) begin
            @(negedge ref_clk);
            waited++;
        end
        check(!rst_pin_n, {tag, " R2 request within limit"}, waited, limit);
        while (!rst_pin_n && len < 100) begin
            if (!rst_req) mism++;
            len++;
            @(negedge ref_clk);
        end
        check(len == PULSE, {tag, " R5 pulse length"}, len, PULSE);
        check(mism == 0, {tag, " R3 pin low with request high"}, mism, 0);
    endtask

    initial begin
        int lows;
        int mism;
        // R9: outputs idle during reset.
        repeat (3) @(negedge ref_clk);
        check(rst_req == 1'b0, "R9 request in reset", int'(rst_req), 0);
        check(rst_pin_n == 1'b1, "R9 pin in reset", int'(rst_pin_n), 1);
        @(negedge ref_clk);
        rst_n = 1'b1;
        enable = 1'b1;

        // R1: sweep healthy periods 2..16 ns.
        for (int p = 2; p <= 16; p++) begin
            mon_half = p / 2.0;
            count_lows(4 * WIN, lows, mism);
            check(lows == 0, $sformatf("R1 period %0d no reset", p), lows, 0);
        end

        // R2/R3/R5: stop the clock while armed.
        mon_half = 0.0;
        expect_fire(FIRE_LIMIT, "stop armed");
        // R6: stays quiet while stopped.
        count_lows(6 * WIN, lows, mism);
        check(lows == 0, "R6 no retrigger while stopped", lows, 0);

        // R6: slow clock does not re-arm; a later stop stays quiet.
        mon_half = 100.0;
        count_lows(6 * WIN, lows, mism);
        check(lows == 0, "R6 slow clock quiet in recover", lows, 0);
        mon_half = 0.0;
        count_lows(6 * WIN, lows, mism);
        check(lows == 0, "R6 stop after slow, not re-armed", lows, 0);

        // R6: 17 ns gives 18-19 edges per window, below the re-arm threshold.
        mon_half = 8.5;
        count_lows(4 * WIN, lows, mism);
        mon_half = 0.0;
        count_lows(6 * WIN, lows, mism);
        check(lows == 0, "R6 19 edges do not re-arm", lows, 0);

        // 15 ns re-arms; R8 slow clock then does not fire while armed.
        mon_half = 7.5;
        count_lows(3 * WIN, lows, mism);
        check(lows == 0, "R1 healthy after re-arm", lows, 0);
        mon_half = 100.0;
        count_lows(6 * WIN, lows, mism);
        check(lows == 0, "R8 slow clock armed no reset", lows, 0);
        mon_half = 0.0;
        expect_fire(FIRE_LIMIT, "stop rearmed");

        // R4: disabled monitor ignores a stopped clock.
        mon_half = 7.5;
        count_lows(3 * WIN, lows, mism);
        enable = 1'b0;
        mon_half = 0.0;
        count_lows(6 * WIN, lows, mism);
        check(lows == 0, "R4 disabled no reset", lows, 0);
        check(mism == 0, "R3 pin matches request disabled", mism, 0);

        // R7: first window after enable discarded, then fires.
        enable = 1'b1;
        count_lows(WIN, lows, mism);
        check(lows == 0, "R7 first window discarded", lows, 0);
        lows = 0;
        while (rst_pin_n && lows < WIN + 8) begin
            @(negedge ref_clk);
            lows++;
        end
        check(!rst_pin_n, "R7 second window fires", lows, WIN + 8);

        // R4: dropping enable during the pulse releases it next cycle.
        enable = 1'b0;
        @(negedge ref_clk);
        check(rst_pin_n == 1'b1, "R4 release on disable", int'(rst_pin_n), 1);
        check(rst_req == 1'b0, "R4 request cleared on disable", int'(rst_req), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #(REF_PERIOD * 150000.0);
        errors++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule